// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter Stage

A 4-bit synchronous counter stage that counts up or down in response to two separate count strobes rather than a clock plus a direction pin. Both strobes idle high. A rising transition on the up strobe adds one to the count, and a rising transition on the down strobe subtracts one. The strobes are sampled by a free-running system clock, passed through a synchronizer, and edge-detected, so everything inside the stage runs on one clock. A parameter selects decade counting (0 to 9) or binary counting (0 to 15).

The stage also has a parallel preset that is active while the load input is low, and a clear that is active high and overrides every other input. The terminal-count outputs are active low. Carry is asserted while the count sits at its top value and the up strobe is low. Borrow is asserted while the count is zero and the down strobe is low. Each of these pulses ends on the same strobe edge that wraps the count. The carry and borrow outputs can therefore drive the up and down strobes of the next stage directly, which lets stages be chained to any width.

Top module: `updn_cascade_counter`

## Requirements
- R1: While clr_i is high at a rising clock edge, count_o is 0 after that edge, whatever load_ni, data_i, up_i and dn_i are doing.
- R2: While load_ni is low and clr_i is low at a rising clock edge, count_o equals data_i after that edge. In decade mode, data values 10 to 15 are loaded unchanged.
- R3: A low-to-high transition of up_i while dn_i is held high increments count_o by one. In binary mode 15 wraps to 0. In decade mode any value of 9 or more wraps to 0.
- R4: A low-to-high transition of dn_i while up_i is held high decrements count_o by one. From 0 the count goes to 15 in binary mode and to 9 in decade mode.
- R5: Each strobe passes through two synchronizer flops and an edge detector. count_o changes at the third rising clock edge after the strobe rises and is still unchanged after the second.
- R6: A high-to-low transition of either strobe leaves count_o unchanged.
- R7: If both strobes rise in the same clock cycle, count_o holds.
- R8: carry_no is low exactly when count_o is at the top value (9 in decade mode, 15 in binary mode), the synchronized up strobe is low, clr_i is low and load_ni is high.
- R9: borrow_no is low exactly when count_o is 0, the synchronized down strobe is low, clr_i is low and load_ni is high.
- R10: After reset, count_o is 0 and carry_no and borrow_no are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples all inputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_i | input | 1 | Up count strobe, idle high; counts on its rising edge |
| dn_i | input | 1 | Down count strobe, idle high; counts on its rising edge |
| clr_i | input | 1 | Clear to zero, active high, highest priority |
| load_ni | input | 1 | Preset load, active low |
| data_i | input | 4 | Preset value |
| count_o | output | 4 | Current count |
| carry_no | output | 1 | Terminal count while counting up, active low |
| borrow_no | output | 1 | Terminal count while counting down, active low |

## Verification
The assertions assume that clr_i, load_ni and data_i are synchronous to clk_i. They also assume that only one strobe is active at a time, with the other held at its idle-high level. Under those assumptions every count step is a legal increment, decrement or hold. The bench drives all inputs half a cycle away from the rising edge. It holds each strobe level for several cycles so that the synchronizer always settles, and it raises both strobes together only in the one test aimed at the simultaneous-edge rule. Every preset value from 0 to 15 is loaded into a binary stage and a decade stage side by side, and each stage is then stepped through more than a full cycle in each direction.

// File: rtl/updn_pkg.sv
package updn_pkg;
  localparam int unsigned CNT_W = 4;
  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t top_val(input logic decade);
    return decade ? cnt_t'(9) : cnt_t'((1 << CNT_W) - 1);
  endfunction

  function automatic cnt_t step_up(input cnt_t v, input logic decade);
    if (v >= top_val(decade)) return '0;
    return v + cnt_t'(1);
  endfunction

  function automatic cnt_t step_dn(input cnt_t v, input logic decade);
    if (v == '0) return top_val(decade);
    return v - cnt_t'(1);
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic lvl_o,
  output logic rise_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  // Idle-high reset value keeps reset release from looking like an edge.
  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[DEPTH-2:0], lvl_i};
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/count_core.sv
module count_core
  import updn_pkg::*;
#(
  parameter bit DECADE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic load_ni,
  input  cnt_t data_i,
  input  logic up_en_i,
  input  logic dn_en_i,
  output cnt_t count_o
);
  cnt_t cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                    cnt_d = '0;
    else if (!load_ni)            cnt_d = data_i;
    else if (up_en_i && !dn_en_i) cnt_d = step_up(cnt_q, DECADE);
    else if (dn_en_i && !up_en_i) cnt_d = step_dn(cnt_q, DECADE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/term_flags.sv
module term_flags
  import updn_pkg::*;
#(
  parameter bit DECADE = 1'b0
) (
  input  cnt_t count_i,
  input  logic up_lvl_i,
  input  logic dn_lvl_i,
  input  logic clr_i,
  input  logic load_ni,
  output logic carry_no,
  output logic borrow_no
);
  localparam cnt_t TOP = top_val(DECADE);

  logic quiet;
  assign quiet     = !clr_i && load_ni;
  assign carry_no  = !(quiet && (count_i == TOP) && !up_lvl_i);
  assign borrow_no = !(quiet && (count_i == '0) && !dn_lvl_i);
endmodule

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter
  import updn_pkg::*;
#(
  parameter bit          DECADE      = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             clr_i,
  input  logic             load_ni,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             carry_no,
  output logic             borrow_no
);
  localparam int unsigned N_STROBE = 2;

  logic [N_STROBE-1:0] raw, lvl, rise;
  assign raw = {dn_i, up_i};

  for (genvar g = 0; g < N_STROBE; g++) begin : g_sync
    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (raw[g]),
      .lvl_o (lvl[g]),
      .rise_o(rise[g])
    );
  end

  count_core #(.DECADE(DECADE)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .load_ni(load_ni),
    .data_i (data_i),
    .up_en_i(rise[0]),
    .dn_en_i(rise[1]),
    .count_o(count_o)
  );

  term_flags #(.DECADE(DECADE)) u_flags (
    .count_i  (count_o),
    .up_lvl_i (lvl[0]),
    .dn_lvl_i (lvl[1]),
    .clr_i    (clr_i),
    .load_ni  (load_ni),
    .carry_no (carry_no),
    .borrow_no(borrow_no)
  );
endmodule

// File: rtl/updn_counter_checker.sv
module updn_counter_checker
  import updn_pkg::*;
#(
  parameter bit DECADE = 1'b0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clr_i,
  input logic       load_ni,
  input logic [3:0] data_i,
  input logic [3:0] count_o,
  input logic       carry_no,
  input logic       borrow_no
);
  localparam cnt_t TOP = top_val(DECADE);

  assert_clear_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_o == '0);

  assert_preset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_ni) |=> count_o == $past(data_i));

  // R3 R4: without clear or load the count only holds or takes one legal step
  assert_legal_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && load_ni) |=> (count_o == $past(count_o)
                          || count_o == step_up($past(count_o), DECADE)
                          || count_o == step_dn($past(count_o), DECADE)));

  assert_carry_cond_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> (count_o == TOP && !clr_i && load_ni));

  assert_borrow_cond_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !borrow_no |-> (count_o == '0 && !clr_i && load_ni));

  assert_flags_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!carry_no && !borrow_no && TOP != '0));
endmodule

bind updn_cascade_counter updn_counter_checker #(.DECADE(DECADE)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_i    (clr_i),
  .load_ni  (load_ni),
  .data_i   (data_i),
  .count_o  (count_o),
  .carry_no (carry_no),
  .borrow_no(borrow_no)
);

// File: tb/tb_updn_cascade_counter.sv
`timescale 1ns/1ps
module tb_updn_cascade_counter;
  logic clk = 0, rst_n = 0;
  logic up = 1, dn = 1, clr = 0, load_n = 1;
  logic [3:0] data = 0;
  logic [3:0] cnt_b, cnt_d;
  logic cy_b, bw_b, cy_d, bw_d;
  int checks = 0, errors = 0;
  logic [3:0] exp_b = 0, exp_d = 0;
  bit done = 0;

  always #5 clk = ~clk;

  updn_cascade_counter #(.DECADE(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .up_i(up), .dn_i(dn), .clr_i(clr),
    .load_ni(load_n), .data_i(data), .count_o(cnt_b), .carry_no(cy_b), .borrow_no(bw_b));

  updn_cascade_counter #(.DECADE(1'b1)) dut_dec (
    .clk_i(clk), .rst_ni(rst_n), .up_i(up), .dn_i(dn), .clr_i(clr),
    .load_ni(load_n), .data_i(data), .count_o(cnt_d), .carry_no(cy_d), .borrow_no(bw_d));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [3:0] m_up(input logic [3:0] v, input int top);
    return (v >= top) ? 4'd0 : v + 4'd1;
  endfunction
  function automatic logic [3:0] m_dn(input logic [3:0] v, input int top);
    return (v == 0) ? 4'(top) : v - 4'd1;
  endfunction

  task automatic do_load(input logic [3:0] v);
    data = v; load_n = 0;
    wait_n(1);
    load_n = 1;
    exp_b = v; exp_d = v;
    chk("R2 bin", cnt_b, v);
    chk("R2 dec", cnt_d, v);
  endtask

  // up strobe pulse; checks carry while low, falling edge inert, count after rise
  task automatic up_pulse;
    up = 0;
    wait_n(4);
    chk("R6 bin", cnt_b, exp_b);
    chk("R8 bin", cy_b, !(exp_b == 15));
    chk("R8 dec", cy_d, !(exp_d == 9));
    up = 1;
    wait_n(4);
    exp_b = m_up(exp_b, 15); exp_d = m_up(exp_d, 9);
    chk("R3 bin", cnt_b, exp_b);
    chk("R3 dec", cnt_d, exp_d);
    chk("R8 idle bin", cy_b, 1);
  endtask

  task automatic dn_pulse;
    dn = 0;
    wait_n(4);
    chk("R6 dec", cnt_d, exp_d);
    chk("R9 bin", bw_b, !(exp_b == 0));
    chk("R9 dec", bw_d, !(exp_d == 0));
    dn = 1;
    wait_n(4);
    exp_b = m_dn(exp_b, 15); exp_d = m_dn(exp_d, 9);
    chk("R4 bin", cnt_b, exp_b);
    chk("R4 dec", cnt_d, exp_d);
    chk("R9 idle bin", bw_b, 1);
  endtask

  initial begin
    wait_n(3);
    chk("R10 count", cnt_b, 0);
    chk("R10 carry", cy_b, 1);
    chk("R10 borrow", bw_d, 1);
    rst_n = 1;
    wait_n(2);

    for (int v = 0; v < 16; v++) begin
      do_load(4'(v));
      for (int k = 0; k < 17; k++) up_pulse();
      do_load(4'(v));
      for (int k = 0; k < 17; k++) dn_pulse();
    end

    // R5: exact latency of the strobe path
    do_load(4'd4);
    up = 0; wait_n(4);
    up = 1;
    @(posedge clk); @(posedge clk); #1;
    chk("R5 unchanged after 2nd edge", cnt_b, 4);
    @(posedge clk); #1;
    chk("R5 changed at 3rd edge", cnt_b, 5);
    wait_n(3);

    // R7: both strobes rise together
    up = 0; dn = 0; wait_n(4);
    up = 1; dn = 1; wait_n(4);
    chk("R7 bin", cnt_b, 5);
    chk("R7 dec", cnt_d, 5);

    // R1: clear beats load and counting; flags held off
    do_load(4'd15);
    up = 0; wait_n(4);
    chk("R8 low at top", cy_b, 0);
    clr = 1; load_n = 0; data = 4'd7;
    #1;
    chk("R8 gated by clear", cy_b, 1);
    up = 1; wait_n(4);
    chk("R1 bin", cnt_b, 0);
    chk("R1 dec", cnt_d, 0);
    dn = 0; wait_n(3);
    chk("R9 gated by clear", bw_b, 1);
    clr = 0; load_n = 1; dn = 1; wait_n(4);
    chk("R4 after clear release", cnt_b, 15);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule